// File: doc/BRIEF.md
# Byte/Word Aliased Register File

This block is the general-purpose register file of a 16-bit processor core. It stores eight 16-bit registers. Four of them are data registers, and each one is also addressable as two separate 8-bit halves. The other four are pointer and index registers, which are always addressed as whole words.

The block has one write port and two read ports. Each port carries a 3-bit register select and a byte/word flag. The same 3-bit select therefore names a whole word in word mode and a single byte lane in byte mode. A byte write merges into one half of the addressed word. A byte read is returned zero-extended on the 16-bit bus.

Reads are combinational from the stored state. Writes take effect at the rising clock edge, so a read in the same cycle as a write to the same register returns the value from before the write.

Top module: `gp_regfile`

## Requirements
- R1: An active-low reset clears all eight registers, so that every word read returns 0x0000.
- R2: In word mode, select values 0 to 7 address, in order, the word registers AX, CX, DX, BX, SP, BP, SI and DI.
- R3: In byte mode, selects 0 to 3 address the low byte (bits 7:0) of AX, CX, DX and BX. Selects 4 to 7 address the high byte (bits 15:8) of the same four registers, in the same order.
- R4: A byte write changes only the addressed byte lane. The other half of that word and all other registers keep their values.
- R5: A byte read drives the selected byte on bits 7:0 of the read bus and drives bits 15:8 to zero.
- R6: A word write replaces all 16 bits of the addressed register. Its halves are then readable as separate bytes.
- R7: A read of a register in the same cycle as a write to it returns the old value. The new value is visible from the next cycle on.
- R8: While the write enable is low, no register changes, whatever the write select and write data are.
- R9: The two read ports are independent. Each port applies its own select and its own width to the same stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write enable |
| wrByte | input | 1 | Write width: 1 = byte, 0 = word |
| wrSel | input | 3 | Write register select |
| wrData | input | 16 | Write data; a byte write uses bits 7:0 |
| rdASel | input | 3 | Read port A select |
| rdAByte | input | 1 | Read port A width: 1 = byte, 0 = word |
| rdAData | output | 16 | Read port A data |
| rdBSel | input | 3 | Read port B select |
| rdBByte | input | 1 | Read port B width: 1 = byte, 0 = word |
| rdBData | output | 16 | Read port B data |

## Verification
Directed patterns come first, and each targets one property:
- A full word write followed by reads of its two byte aliases separates the high-lane mapping from the low-lane mapping.
- A byte write into a register that already holds a nonzero word shows whether the other half is preserved or overwritten.
- Writing a distinct word to every select and then reading each one back tells the word encoding apart from the byte encoding.
- Same-cycle write and read of one register separates old-value read behaviour from write-through.

After these, seeded random mixes of byte and word writes, with random widths on both read ports, compare the block against a bench model of the lane merge. This catches wrong lane strobes that the directed values happen to mask.

// File: rtl/gp_regfile_pkg.sv
package gp_regfile_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int SEL_W    = 3;
  localparam int NUM_REGS = 1 << SEL_W;
  localparam int PAIR_W   = SEL_W - 1;   // index width of byte-addressable words

  // write strobes from control to datapath
  typedef struct packed {
    logic              loEn;
    logic              hiEn;
    logic [SEL_W-1:0]  idx;
    logic [WORD_W-1:0] data;
  } wrStrobe_t;

  // read steering for one port
  typedef struct packed {
    logic             byteMode;
    logic             hiLane;
    logic [SEL_W-1:0] idx;
  } rdStrobe_t;
endpackage

// File: rtl/gp_regfile_ctrl.sv
module gp_regfile_ctrl
  import gp_regfile_pkg::*;
(
  input  logic              wrEn,
  input  logic              wrByte,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [WORD_W-1:0] wrData,
  input  logic [SEL_W-1:0]  rdASel,
  input  logic              rdAByte,
  input  logic [SEL_W-1:0]  rdBSel,
  input  logic              rdBByte,
  output wrStrobe_t         wrStb,
  output rdStrobe_t         rdAStb,
  output rdStrobe_t         rdBStb
);
  // byte mode: low select bits pick the pair, the top bit picks the lane
  function automatic rdStrobe_t decodeRead(input logic [SEL_W-1:0] sel, input logic isByte);
    rdStrobe_t r;
    r.byteMode = isByte;
    r.hiLane   = isByte & sel[SEL_W-1];
    r.idx      = isByte ? {1'b0, sel[PAIR_W-1:0]} : sel;
    return r;
  endfunction

  always_comb begin
    wrStb.idx  = wrByte ? {1'b0, wrSel[PAIR_W-1:0]} : wrSel;
    wrStb.loEn = wrEn & (~wrByte | ~wrSel[SEL_W-1]);
    wrStb.hiEn = wrEn & (~wrByte |  wrSel[SEL_W-1]);
    // a byte write to the high lane carries its payload up
    wrStb.data = (wrByte & wrSel[SEL_W-1]) ? {wrData[BYTE_W-1:0], wrData[BYTE_W-1:0]} : wrData;
  end

  assign rdAStb = decodeRead(rdASel, rdAByte);
  assign rdBStb = decodeRead(rdBSel, rdBByte);
endmodule

// File: rtl/gp_regfile_dp.sv
module gp_regfile_dp
  import gp_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         wrStb,
  input  rdStrobe_t         rdAStb,
  input  rdStrobe_t         rdBStb,
  output logic [WORD_W-1:0] rdAData,
  output logic [WORD_W-1:0] rdBData
);
  logic [WORD_W-1:0] regQ [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ[i] <= '0;
      end else if (wrStb.idx == SEL_W'(i)) begin
        if (wrStb.loEn) regQ[i][BYTE_W-1:0]      <= wrStb.data[BYTE_W-1:0];
        if (wrStb.hiEn) regQ[i][WORD_W-1:BYTE_W] <= wrStb.data[WORD_W-1:BYTE_W];
      end
    end

    // R4: lone low-lane write leaves high lane intact, and vice versa
    assert_lo_write_keeps_hi_R4: assert property (@(posedge clk) disable iff (!rstN)
      (wrStb.loEn && !wrStb.hiEn && wrStb.idx == SEL_W'(i))
        |=> $stable(regQ[i][WORD_W-1:BYTE_W]));
    assert_hi_write_keeps_lo_R4: assert property (@(posedge clk) disable iff (!rstN)
      (wrStb.hiEn && !wrStb.loEn && wrStb.idx == SEL_W'(i))
        |=> $stable(regQ[i][BYTE_W-1:0]));
    // R8: no strobes, no change
    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
      !(wrStb.loEn || wrStb.hiEn) |=> $stable(regQ[i]));
  end

  // R6: a full-width write lands whole
  assert_word_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.loEn && wrStb.hiEn) |=> regQ[$past(wrStb.idx)] == $past(wrStb.data));

  function automatic logic [WORD_W-1:0] steer(input rdStrobe_t s, input logic [WORD_W-1:0] w);
    if (!s.byteMode)  return w;
    else if (s.hiLane) return {{BYTE_W{1'b0}}, w[WORD_W-1:BYTE_W]};
    else               return {{BYTE_W{1'b0}}, w[BYTE_W-1:0]};
  endfunction

  assign rdAData = steer(rdAStb, regQ[rdAStb.idx]);
  assign rdBData = steer(rdBStb, regQ[rdBStb.idx]);

  // R5: byte reads are zero-extended
  assert_zero_ext_a_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdAStb.byteMode |-> rdAData[WORD_W-1:BYTE_W] == '0);
  assert_zero_ext_b_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdBStb.byteMode |-> rdBData[WORD_W-1:BYTE_W] == '0);
endmodule

// File: rtl/gp_regfile.sv
module gp_regfile
  import gp_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrByte,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [WORD_W-1:0] wrData,
  input  logic [SEL_W-1:0]  rdASel,
  input  logic              rdAByte,
  output logic [WORD_W-1:0] rdAData,
  input  logic [SEL_W-1:0]  rdBSel,
  input  logic              rdBByte,
  output logic [WORD_W-1:0] rdBData
);
  wrStrobe_t wrStb;
  rdStrobe_t rdAStb;
  rdStrobe_t rdBStb;

  gp_regfile_ctrl uCtrl (
    .wrEn(wrEn), .wrByte(wrByte), .wrSel(wrSel), .wrData(wrData),
    .rdASel(rdASel), .rdAByte(rdAByte), .rdBSel(rdBSel), .rdBByte(rdBByte),
    .wrStb(wrStb), .rdAStb(rdAStb), .rdBStb(rdBStb)
  );

  gp_regfile_dp uDp (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdAStb(rdAStb), .rdBStb(rdBStb),
    .rdAData(rdAData), .rdBData(rdBData)
  );

  // R3: byte writes strobe exactly one lane
  assert_byte_one_lane_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrByte) |-> $countones({wrStb.loEn, wrStb.hiEn}) == 1);
endmodule

// File: tb/tb_gp_regfile.sv
module tb_gp_regfile;
  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0, wrByte = 0;
  logic [2:0]  wrSel = 0;
  logic [15:0] wrData = 0;
  logic [2:0]  rdASel = 0, rdBSel = 0;
  logic        rdAByte = 0, rdBByte = 0;
  logic [15:0] rdAData, rdBData;

  int errors = 0;
  int checks = 0;
  logic [15:0] model [8];

  always #2 clk = ~clk;   // 250 MHz

  gp_regfile dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrByte(wrByte), .wrSel(wrSel), .wrData(wrData),
    .rdASel(rdASel), .rdAByte(rdAByte), .rdAData(rdAData),
    .rdBSel(rdBSel), .rdBByte(rdBByte), .rdBData(rdBData)
  );

  function automatic logic [15:0] expRead(input logic [2:0] sel, input logic isByte);
    logic [15:0] w;
    if (!isByte) return model[sel];
    w = model[{1'b0, sel[1:0]}];
    return sel[2] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  task automatic modelWrite(input logic isByte, input logic [2:0] sel, input logic [15:0] d);
    if (!isByte) model[sel] = d;
    else if (sel[2]) model[{1'b0, sel[1:0]}][15:8] = d[7:0];
    else model[{1'b0, sel[1:0]}][7:0] = d[7:0];
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check reads before the edge, then commit model
  task automatic step(input logic we, input logic wb, input logic [2:0] ws, input logic [15:0] wd,
                      input logic [2:0] as, input logic ab, input logic [2:0] bs, input logic bb,
                      input string tag);
    @(negedge clk);
    wrEn = we; wrByte = wb; wrSel = ws; wrData = wd;
    rdASel = as; rdAByte = ab; rdBSel = bs; rdBByte = bb;
    #1;
    check({tag, " portA"}, rdAData, expRead(as, ab));
    check({tag, " portB"}, rdBData, expRead(bs, bb));
    @(posedge clk);
    if (we) modelWrite(wb, ws, wd);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    for (int i = 0; i < 8; i++) model[i] = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1: all zero after reset
    for (int i = 0; i < 8; i += 2)
      step(0, 0, 0, 16'hFFFF, 3'(i), 0, 3'(i + 1), 0, "R1 reset");

    // R2: distinct word per select, read back by word
    for (int i = 0; i < 8; i++)
      step(1, 0, 3'(i), 16'h1111 * 16'(i + 1) ^ 16'h0F0F, 3'(i), 0, 3'(i), 1, "R2 R7 write");
    for (int i = 0; i < 8; i++)
      step(0, 0, 0, 0, 3'(i), 0, 3'(7 - i), 0, "R2 word map");

    // R6 R3 R5: word write then byte aliases
    step(1, 0, 3'd0, 16'h1234, 3'd0, 0, 3'd0, 0, "R7 same cycle");
    step(0, 0, 0, 0, 3'd0, 1, 3'd4, 1, "R6 R3 R5 AX halves");
    check("R5 AL zero-ext", rdAData, 16'h0034);
    check("R3 AH", rdBData, 16'h0012);

    // R4: high-lane byte write to BX keeps low lane
    step(1, 1, 3'd7, 16'hFFAB, 3'd3, 0, 3'd7, 1, "R4 BH write");
    step(0, 0, 0, 0, 3'd3, 0, 3'd3, 1, "R4 BX after BH");
    check("R4 BX merged", rdAData, {8'hAB, model[3][7:0]});
    // R4: low-lane write to DX keeps high lane
    step(1, 1, 3'd2, 16'h77CD, 3'd2, 0, 3'd6, 1, "R4 DL write");
    step(0, 0, 0, 0, 3'd2, 0, 3'd6, 1, "R4 DX after DL");
    check("R4 DL lane", rdAData[7:0], 8'hCD);

    // R8: disabled write with live select and data
    step(0, 0, 3'd1, 16'hDEAD, 3'd1, 0, 3'd5, 1, "R8 idle");
    step(0, 1, 3'd5, 16'hBEEF, 3'd1, 0, 3'd5, 1, "R8 after idle");

    // R9 R7: random mix
    seed = $urandom(32'h5EED);
    for (int n = 0; n < 400; n++)
      step(1'($urandom % 4 != 0), 1'($urandom), 3'($urandom), 16'($urandom),
           3'($urandom), 1'($urandom), 3'($urandom), 1'($urandom), "R9 R4 random");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule